// File: doc/BRIEF.md
# GPIO Interrupt Latch with Dual Enables

This block collects interrupt conditions from a bank of general-purpose input pins and presents them to a processor as one summary interrupt line. Each pin first passes through a two-flop synchronizer. Its configured condition is then detected: a level (active-high or active-low) or an edge (rising or falling). A detected condition is latched into a per-pin status bit, and only pins that are allowed to forward are ORed into the registered summary output.

Two separate per-pin enables control the path. The raw enable decides whether a detected condition may set the status bit. The forward enable decides whether a set status bit reaches the summary line. Software acknowledges a pin by writing one to its status bit.

A level source that is still active re-latches straight through an acknowledge while its raw enable is set. Software that masks a level pin should therefore clear the raw enable, so the pin cannot latch during handling. For edge pins, the edge detector keeps tracking the input while the raw enable is clear, so setting the raw enable again never creates a false edge.

Top module: `gpio_irq_latch`

## Requirements
- R1: After reset every status bit is 0, the summary output is 0 and every configuration word reads 0.
- R2: Pin p has a configuration word at address p (0..N_PINS-1) with bit 0 trigger type (0 level, 1 edge), bit 1 polarity, bit 2 raw enable and bit 3 forward enable. Writes are read back, and unused upper bits read 0.
- R3: In level mode, polarity 0 means active-high and polarity 1 means active-low. An active input with the raw enable set sets the pin's status bit, and the status read shows it within 4 cycles of the pin change (two synchronizer flops plus the status flop).
- R4: In edge mode, polarity 0 latches a rising edge and polarity 1 latches a falling edge. After an acknowledge the status stays clear while the input holds its new level.
- R5: The status word is at address N_PINS, with bit p for pin p. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R6: When a set condition and an acknowledge meet in the same cycle, the set wins. A level pin that is still active with the raw enable set therefore stays pending through an acknowledge.
- R7: While a pin's raw enable is clear, no input change sets its status bit. A status bit that is already set stays set until it is acknowledged.
- R8: A level pin whose raw enable was cleared, then acknowledged, and whose input went inactive before the raw enable was set again, reports no pending interrupt afterwards.
- R9: An edge pin whose input changed while its raw enable was clear reports no event when the raw enable is set again.
- R10: The summary output is a register holding the OR of all status bits whose forward enable is set. It rises one cycle after such a bit sets and falls one cycle after the last one clears. A status bit whose forward enable is clear does not raise the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | N_PINS | Asynchronous general-purpose inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (configuration words, then status) |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr (combinational) |
| irq_o | output | 1 | Registered summary interrupt |

## Verification
The bench drives active-high and active-low levels, rising and falling edges, and stable inputs, each on its own pin. This tells apart a pin that latches a level, one that latches a transition, and one that wrongly treats a steady input as an event. Acknowledges are issued while a level source is still active and again after its raw enable is cleared; the first must keep the pin pending and the second must clear it. Edges and level drops are placed inside windows where the raw enable is clear, to show that setting the enable again brings back neither a stale level nor a false edge. The summary is observed with forward enables on and off, and in the cycles around a clear, to confirm its one-cycle registered lag.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int CFG_W = 4;

    // Bit 0 trigger, bit 1 polarity, bit 2 raw enable, bit 3 forward enable
    typedef struct packed {
        logic fwd_en;
        logic raw_en;
        logic pol;
        logic trig;   // 0 level, 1 edge
    } pin_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;

    assert_sync_pipe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.s2 == $past(st_q.s1)));
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_s,
    input  pin_cfg_t cfg,
    input  logic     ack,
    output logic     status_o,
    output logic     fwd_o
);
    typedef struct packed {
        logic prev;
        logic status;
    } pin_st_t;

    pin_st_t st_d, st_q;
    logic    lvl_act, edge_ev, cond, set_ev;

    always_comb begin
        lvl_act = pin_s ^ cfg.pol;
        edge_ev = cfg.pol ? (!pin_s && st_q.prev) : (pin_s && !st_q.prev);
        cond    = cfg.trig ? edge_ev : lvl_act;
        set_ev  = cfg.raw_en && cond;

        st_d        = st_q;
        st_d.prev   = pin_s;  // tracks regardless of raw enable
        st_d.status = set_ev || (st_q.status && !ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign fwd_o    = st_q.status && cfg.fwd_en;

    assert_no_set_raw_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.raw_en && !st_q.status) |=> !st_q.status);
    assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status && !ack) |=> st_q.status);
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.status && ack && !cfg.raw_en) |=> !st_q.status);
    assert_level_relatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.trig && cfg.raw_en && (pin_s != cfg.pol)) |=> st_q.status);
    assert_edge_no_false_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.trig && $stable(pin_s) && !st_q.status) |=> !st_q.status);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 4,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [N_PINS-1:0] status_i,
    output pin_cfg_t          cfg_o [N_PINS],
    output logic [N_PINS-1:0] ack_o,
    output logic [REG_W-1:0]  reg_rdata
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(N_PINS);

    typedef struct packed {
        pin_cfg_t [N_PINS-1:0] cfg;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < N_PINS; p++) begin
            if (reg_we && reg_addr == ADDR_W'(p))
                st_d.cfg[p] = pin_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ack_o = (reg_we && reg_addr == STAT_ADDR) ? reg_wdata[N_PINS-1:0] : '0;
    end

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < N_PINS; p++) begin
            if (reg_addr == ADDR_W'(p))
                reg_rdata = REG_W'(st_q.cfg[p]);
        end
        if (reg_addr == STAT_ADDR)
            reg_rdata = REG_W'(status_i);
    end

    for (genvar g = 0; g < N_PINS; g++) begin : g_cfg
        assign cfg_o[g] = st_q.cfg[g];
    end

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 0) |=> (st_q.cfg[0] == $past(reg_wdata[CFG_W-1:0])));
endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch
    import gpio_irq_pkg::*;
#(
    parameter int N_PINS = 8,
    localparam int ADDR_W = $clog2(N_PINS + 1),
    localparam int REG_W  = (N_PINS > CFG_W) ? N_PINS : CFG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pins_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic summary;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [N_PINS-1:0] pins_s, status, ack, fwd;
    pin_cfg_t          cfg [N_PINS];

    gpio_irq_sync #(.WIDTH(N_PINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(pins_s)
    );

    gpio_irq_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W), .REG_W(REG_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status_i(status), .cfg_o(cfg), .ack_o(ack),
        .reg_rdata(reg_rdata)
    );

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        gpio_irq_pin pin_i (
            .clk(clk), .rst_n(rst_n), .pin_s(pins_s[g]), .cfg(cfg[g]),
            .ack(ack[g]), .status_o(status[g]), .fwd_o(fwd[g])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.summary = |fwd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.summary;

    assert_summary_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & fwd)) |=> irq_o);
    assert_summary_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !irq_o);
endmodule

// File: tb/gpio_irq_latch_tb_top.sv
module gpio_irq_latch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int AW = $clog2(N + 1);
    localparam int RW = 8;
    localparam logic [AW-1:0] STAT = AW'(N);

    logic          clk = 0;
    logic          rst_n = 0;
    logic [N-1:0]  pins = '0;
    logic          we = 0;
    logic [AW-1:0] addr = '0;
    logic [RW-1:0] wdata = '0;
    logic [RW-1:0] rdata;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpio_irq_latch #(.N_PINS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        we = 1; addr = a; wdata = d;
        @(negedge clk);
        we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [RW-1:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic stat_bit(input string req, input string what, input int p, input logic exp);
        logic [RW-1:0] d;
        rd(STAT, d);
        check(req, what, 32'(d[p]), 32'(exp));
    endtask

    task automatic t_reset;
        logic [RW-1:0] d;
        rd(STAT, d);      check("R1", "status after reset", 32'(d), 0);
        rd(0, d);         check("R1", "cfg0 after reset", 32'(d), 0);
        check("R1", "irq after reset", 32'(irq), 0);
    endtask

    task automatic t_cfg;
        logic [RW-1:0] d;
        wr(3, 8'hFF);
        rd(3, d);         check("R2", "cfg3 readback masked", 32'(d), 32'h0F);
        wr(3, 8'h05);
        rd(3, d);         check("R2", "cfg3 readback", 32'(d), 32'h05);
        wr(3, 8'h00);
    endtask

    task automatic t_level_high;
        wr(1, 8'h04);                    // level, high, raw on, fwd off
        pins[1] = 1;
        wait_cyc(4);
        stat_bit("R3", "level high latched", 1, 1);
        check("R10", "no summary with fwd off", 32'(irq), 0);
        wr(1, 8'h0C);                    // fwd on
        wait_cyc(1);
        check("R10", "summary with fwd on", 32'(irq), 1);
        wr(STAT, 8'h02);
        stat_bit("R6", "active level survives ack", 1, 1);
        wr(1, 8'h08);                    // raw off, fwd on
        wr(STAT, 8'h02);
        stat_bit("R5", "ack clears after raw off", 1, 0);
        check("R10", "summary lags clear by one cycle", 32'(irq), 1);
        wait_cyc(1);
        check("R10", "summary falls", 32'(irq), 0);
        pins[1] = 0;
        wait_cyc(4);
        wr(1, 8'h0C);                    // raw back on
        wait_cyc(4);
        stat_bit("R8", "no extra pending after re-enable", 1, 0);
        check("R8", "no summary after re-enable", 32'(irq), 0);
        wr(1, 8'h00);
    endtask

    task automatic t_level_low;
        wait_cyc(4);
        stat_bit("R3", "active-low idle before config", 2, 0);
        wr(2, 8'h06);                    // level, low, raw on
        wait_cyc(2);
        stat_bit("R3", "active-low latched on low input", 2, 1);
        pins[2] = 1;
        wr(2, 8'h02);
        wr(STAT, 8'h04);
        wait_cyc(4);
        stat_bit("R3", "active-low cleared when high", 2, 0);
    endtask

    task automatic t_edge_rise;
        wr(4, 8'h05);                    // edge, rising, raw on
        wait_cyc(4);
        stat_bit("R4", "no event on steady low", 4, 0);
        pins[4] = 1;
        wait_cyc(4);
        stat_bit("R4", "rising edge latched", 4, 1);
        wr(STAT, 8'h00);
        stat_bit("R5", "write zero keeps status", 4, 1);
        wr(STAT, 8'h10);
        wait_cyc(3);
        stat_bit("R4", "held high stays clear after ack", 4, 0);
    endtask

    task automatic t_edge_fall;
        pins[5] = 1;
        wait_cyc(4);
        wr(5, 8'h07);                    // edge, falling, raw on
        wait_cyc(4);
        stat_bit("R4", "no event on steady high", 5, 0);
        pins[5] = 0;
        wait_cyc(4);
        stat_bit("R4", "falling edge latched", 5, 1);
        wr(STAT, 8'h20);
        stat_bit("R5", "falling ack clears", 5, 0);
    endtask

    task automatic t_raw_off;
        pins[4] = 0;
        wait_cyc(4);
        pins[4] = 1;
        wait_cyc(4);
        stat_bit("R7", "set before raw off", 4, 1);
        wr(4, 8'h01);                    // edge, rising, raw off
        wait_cyc(3);
        stat_bit("R7", "stays set with raw off", 4, 1);
        wr(STAT, 8'h10);
        pins[4] = 0;
        wait_cyc(4);
        pins[4] = 1;
        wait_cyc(4);
        stat_bit("R7", "edge ignored with raw off", 4, 0);
    endtask

    task automatic t_edge_reenable;
        wr(6, 8'h09);                    // edge, rising, raw off, fwd on
        pins[6] = 1;
        wait_cyc(4);
        wr(6, 8'h0D);                    // raw on
        wait_cyc(4);
        stat_bit("R9", "no false edge on re-enable", 6, 0);
        check("R9", "no summary on re-enable", 32'(irq), 0);
        pins[6] = 0;
        wait_cyc(2);
        pins[6] = 1;
        wait_cyc(4);
        stat_bit("R9", "real edge after re-enable", 6, 1);
        check("R10", "summary from edge pin", 32'(irq), 1);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        rst_n = 1;
        wait_cyc(2);
        t_cfg();
        t_level_high();
        t_level_low();
        t_edge_rise();
        t_edge_fall();
        t_raw_off();
        t_edge_reenable();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule